// File: doc/BRIEF.md
# Lockable SMBASE Protection Register

This block is one byte of configuration state that guards a fixed, protected RAM window at the SMBASE address. Firmware negotiates with it in three steps. It first asks whether the protection is offered, by writing a query code. It then reads an "available" answer. Finally it writes a lock bit. From the lock onward, ordinary (non-SMM) accesses to the window are blocked: reads return all ones and writes never reach memory. At the same time an SMM-only window onto the RAM behind it is enabled.

The register's write mask moves through three states: fully open after reset, reduced to the lock bit once the query has been answered, and fully closed once locked. While the mask is still fully open, any write other than the query code is thrown away and the register falls back to zero. This stops early, unaware firmware from arming the lock by accident. The register is evaluated only when a configuration write hits its own byte address. A build parameter can remove the feature, and every write then has no side effect.

The normal-access gate sits beside the register. It returns read data one cycle after a request and forwards normal writes to memory only while the window is not blocked. Address decoding and the memory itself are outside the block.

Top module: `smb_guard`

## Requirements
- R1: After reset the register reads 0x00, both window enables are 0, and normal reads pass the memory data through.
- R2: A write of the query code 0xFF to the register address while the mask is fully open makes the register read 0x01 from the next cycle. Both window enables stay 0.
- R3: While the mask is fully open, a write of any value other than 0xFF (including 0x02) leaves the register at 0x00 and both window enables at 0.
- R4: After the query, only bit 1 is writable: writing 0xFC leaves the register at 0x01 with both enables 0.
- R5: After the query, a write whose data has bit 1 set locks the register. It then reads exactly 0x02, and both the normal-access block enable and the SMM window enable become 1 in the same cycle.
- R6: Once locked, writes of 0xFF, 0x00 or 0xFD leave the register at 0x02 and both enables at 1, until reset.
- R7: Configuration writes to any other byte address change neither the register nor the enables.
- R8: While the block enable is 1, a normal read returns all ones one cycle after the request, and a normal write is not forwarded to memory. While it is 0, the read returns the memory data and the write is forwarded one cycle later.
- R9: With the feature parameter off, every write, including the full query-and-lock sequence, leaves the register at 0x00 and both enables at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_addr | input | ADDR_W | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| smb_reg_o | output | 8 | Current register value (read-back) |
| blk_en_o | output | 1 | Block window for normal accesses enabled |
| smm_win_en_o | output | 1 | SMM-visible RAM window enabled |
| nrm_rd_en | input | 1 | Normal read request to the window |
| nrm_wr_en | input | 1 | Normal write request to the window |
| mem_rdata | input | WIN_DW | Data from the memory behind the window |
| nrm_rd_vld_o | output | 1 | Normal read response valid |
| nrm_rdata_o | output | WIN_DW | Normal read response data |
| mem_wr_en_o | output | 1 | Normal write forwarded to memory |

## Verification
The bench builds two copies side by side on shared inputs. The first has the feature on, with the register at address 0x9C and a 32-bit window. The second is identical except that the feature parameter is off. The first copy reaches the whole negotiation: early discards, masking after the query, the one-way lock, and blocked versus passed-through window traffic. The second shows that the same write sequence leaves a feature-off build fully inert.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [1:0] {
    ST_OPEN = 2'd0,
    ST_NEGO = 2'd1,
    ST_LOCK = 2'd2
  } smb_state_e;
endpackage

// File: rtl/smb_reg_core.sv
module smb_reg_core #(
  parameter int unsigned     ADDR_W     = 8,
  parameter logic [7:0]      REG_ADDR   = 8'h9C,
  parameter bit              FEATURE_EN = 1'b1,
  parameter logic [7:0]      QUERY_CODE = 8'hFF,
  parameter logic [7:0]      AVAIL_CODE = 8'h01,
  parameter logic [7:0]      LOCK_BIT   = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        val_o,
  output logic              blk_en_o,
  output logic              smm_en_o
);
  import smb_pkg::*;

  localparam logic [7:0] MASK_OPEN = 8'hFF;
  localparam logic [7:0] MASK_NEGO = LOCK_BIT;
  localparam logic [7:0] MASK_SHUT = 8'h00;
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  smb_state_e state_q, state_d;
  logic [7:0] val_q, val_d, mask, merged, filt;
  logic       lck_d, hit;

  assign hit = FEATURE_EN && wr_en && (addr == HIT_ADDR);

  always_comb begin
    unique case (state_q)
      ST_OPEN: mask = MASK_OPEN;
      ST_NEGO: mask = MASK_NEGO;
      default: mask = MASK_SHUT;
    endcase
    merged  = (val_q & ~mask) | (wdata & mask);
    filt    = (state_q == ST_OPEN) ? 8'h00 : merged;
    state_d = state_q;
    val_d   = val_q;
    lck_d   = blk_en_o;
    if (hit) begin
      if (merged == QUERY_CODE) begin
        state_d = ST_NEGO;
        val_d   = AVAIL_CODE;
      end else if ((filt & LOCK_BIT) != 8'h00) begin
        state_d = ST_LOCK;
        val_d   = LOCK_BIT;
        lck_d   = 1'b1;
      end else begin
        val_d   = filt;
        lck_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_OPEN;
      val_q    <= 8'h00;
      blk_en_o <= 1'b0;
      smm_en_o <= 1'b0;
    end else begin
      state_q  <= state_d;
      val_q    <= val_d;
      blk_en_o <= lck_d;
      smm_en_o <= lck_d;
    end
  end

  assign val_o = val_q;

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCK) |=> (state_q == ST_LOCK));

  // R5
  lock_value_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCK) |-> (val_q == LOCK_BIT && blk_en_o && smm_en_o));

  // R3
  open_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPEN) |-> (val_q == 8'h00 && !blk_en_o));

  // R4
  nego_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NEGO) |-> ((val_q & ~LOCK_BIT) == (AVAIL_CODE & ~LOCK_BIT)));

  generate
    if (!FEATURE_EN) begin : g_off_chk
      // R9
      feature_off_chk: assert property (@(posedge clk) disable iff (rst)
        (val_q == 8'h00 && !smm_en_o));
    end
  endgenerate
endmodule

// File: rtl/smb_window_gate.sv
module smb_window_gate #(
  parameter int unsigned WIN_DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blk_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [WIN_DW-1:0] mem_rdata_i,
  output logic              rd_vld_o,
  output logic [WIN_DW-1:0] rd_data_o,
  output logic              wr_fwd_o
);
  localparam logic [WIN_DW-1:0] ALL_ONES = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_o  <= 1'b0;
      rd_data_o <= '0;
      wr_fwd_o  <= 1'b0;
    end else begin
      rd_vld_o  <= rd_en_i;
      rd_data_o <= rd_en_i ? (blk_i ? ALL_ONES : mem_rdata_i) : '0;
      wr_fwd_o  <= wr_en_i & ~blk_i;
    end
  end

  // R8
  blocked_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && blk_i) |=> (rd_vld_o && rd_data_o == ALL_ONES));

  // R8
  blocked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && blk_i) |=> !wr_fwd_o);
endmodule

// File: rtl/smb_guard.sv
module smb_guard #(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [7:0]  REG_ADDR   = 8'h9C,
  parameter bit          FEATURE_EN = 1'b1,
  parameter int unsigned WIN_DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        smb_reg_o,
  output logic              blk_en_o,
  output logic              smm_win_en_o,
  input  logic              nrm_rd_en,
  input  logic              nrm_wr_en,
  input  logic [WIN_DW-1:0] mem_rdata,
  output logic              nrm_rd_vld_o,
  output logic [WIN_DW-1:0] nrm_rdata_o,
  output logic              mem_wr_en_o
);
  smb_reg_core #(
    .ADDR_W    (ADDR_W),
    .REG_ADDR  (REG_ADDR),
    .FEATURE_EN(FEATURE_EN),
    .QUERY_CODE(8'hFF),
    .AVAIL_CODE(8'h01),
    .LOCK_BIT  (8'h02)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .val_o   (smb_reg_o),
    .blk_en_o(blk_en_o),
    .smm_en_o(smm_win_en_o)
  );

  smb_window_gate #(.WIN_DW(WIN_DW)) u_gate (
    .clk        (clk),
    .rst        (rst),
    .blk_i      (blk_en_o),
    .rd_en_i    (nrm_rd_en),
    .wr_en_i    (nrm_wr_en),
    .mem_rdata_i(mem_rdata),
    .rd_vld_o   (nrm_rd_vld_o),
    .rd_data_o  (nrm_rdata_o),
    .wr_fwd_o   (mem_wr_en_o)
  );
endmodule

// File: tb/smb_guard_test.sv
`timescale 1ns/1ps
module smb_guard_test;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [7:0] RA = 8'h9C;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wr_en = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic nrm_rd_en = 1'b0, nrm_wr_en = 1'b0;
  logic [DW-1:0] mem_rdata = 32'h1234_5678;

  logic [7:0] reg_a, reg_b;
  logic blk_a, smm_a, blk_b, smm_b;
  logic vld_a, vld_b, wf_a, wf_b;
  logic [DW-1:0] rd_a, rd_b;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  smb_guard #(.ADDR_W(AW), .REG_ADDR(RA), .FEATURE_EN(1'b1), .WIN_DW(DW)) uut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smb_reg_o(reg_a), .blk_en_o(blk_a),
    .smm_win_en_o(smm_a), .nrm_rd_en(nrm_rd_en), .nrm_wr_en(nrm_wr_en),
    .mem_rdata(mem_rdata), .nrm_rd_vld_o(vld_a), .nrm_rdata_o(rd_a),
    .mem_wr_en_o(wf_a));

  smb_guard #(.ADDR_W(AW), .REG_ADDR(RA), .FEATURE_EN(1'b0), .WIN_DW(DW)) uut_off (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smb_reg_o(reg_b), .blk_en_o(blk_b),
    .smm_win_en_o(smm_b), .nrm_rd_en(nrm_rd_en), .nrm_wr_en(nrm_wr_en),
    .mem_rdata(mem_rdata), .nrm_rd_vld_o(vld_b), .nrm_rdata_o(rd_b),
    .mem_wr_en_o(wf_b));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [AW-1:0] a, input logic [7:0] d);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic check_state(input string req, input logic [7:0] v, input logic en);
    check(req, reg_a, v);
    check(req, blk_a, en);
    check(req, smm_a, en);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  // R8 helper: one normal read and write, sampled a cycle later
  task automatic window_access(input string req, input logic blocked);
    nrm_rd_en = 1'b1; nrm_wr_en = 1'b1;
    @(negedge clk);
    nrm_rd_en = 1'b0; nrm_wr_en = 1'b0;
    check(req, vld_a, 1'b1);
    check(req, rd_a, blocked ? 32'hFFFF_FFFF : mem_rdata);
    check(req, wf_a, !blocked);
  endtask

  task automatic t_reset();
    do_reset();
    check_state("R1", 8'h00, 1'b0);
    window_access("R1", 1'b0);
  endtask

  task automatic t_early_discard();
    do_reset();
    cfg_write(RA, 8'h02);
    check_state("R3", 8'h00, 1'b0);
    cfg_write(RA, 8'h5A);
    check_state("R3", 8'h00, 1'b0);
  endtask

  task automatic t_other_addr();
    do_reset();
    cfg_write(8'h9D, 8'hFF);
    check_state("R7", 8'h00, 1'b0);
    cfg_write(RA, 8'hFF);
    cfg_write(8'h9B, 8'h02);
    check_state("R7", 8'h01, 1'b0);
  endtask

  task automatic t_full_sequence();
    do_reset();
    cfg_write(RA, 8'hFF);
    check_state("R2", 8'h01, 1'b0);
    cfg_write(RA, 8'hFC);
    check_state("R4", 8'h01, 1'b0);
    window_access("R8", 1'b0);
    cfg_write(RA, 8'h02);
    check_state("R5", 8'h02, 1'b1);
    window_access("R8", 1'b1);
    mem_rdata = 32'h0BAD_F00D;
    window_access("R8", 1'b1);
    cfg_write(RA, 8'hFF);
    check_state("R6", 8'h02, 1'b1);
    cfg_write(RA, 8'h00);
    check_state("R6", 8'h02, 1'b1);
    cfg_write(RA, 8'hFD);
    check_state("R6", 8'h02, 1'b1);
  endtask

  task automatic t_feature_off();
    do_reset();
    cfg_write(RA, 8'hFF);
    check("R9", reg_b, 8'h00);
    cfg_write(RA, 8'h02);
    check("R9", reg_b, 8'h00);
    check("R9", blk_b, 1'b0);
    check("R9", smm_b, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_early_discard();
    t_other_addr();
    t_full_sequence();
    t_feature_off();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule